// File: doc/BRIEF.md
# Multicycle Processor Datapath with Unified Memory

This block is the 32-bit datapath of a processor that spends several clock cycles on each instruction. It has no sequencer of its own. An external controller drives a set of select and enable lines on every cycle, and the datapath returns the opcode of the held instruction and the ALU zero flag so that the controller can choose its next step. Each cycle performs one register transfer. A full instruction is built from a sequence of such cycles: fetch, decode and operand read, execute, memory access, and write-back.

The block holds the program counter, an instruction register, a memory data register, two operand latches, and a latch for the ALU result. It also holds a 32-entry register file and a 256-word memory. One address mux lets that memory serve both instruction fetches and data accesses. The one ALU computes the PC increment and the branch target as well as the instruction's own operation. An image load port writes words straight into memory so that a program can be placed there before it runs.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-low reset clears the PC, the instruction, memory-data, operand and ALU-result registers, and every register-file entry. After reset, pc_o, opcode_o and aluout_o all read zero.
- R2: Memory is indexed by byte-address bits [9:2]. addr_sel=0 takes that address from the PC and addr_sel=1 takes it from the ALU-result register. Read data is the addressed word when mem_rd=1 and zero otherwise. The instruction register loads the read data only when ir_load=1. The memory-data register loads it on every cycle. opcode_o is instruction bits [31:26].
- R3: Operand A is the PC when src_a_sel=0 and the A latch when src_a_sel=1. Operand B is chosen by src_b_sel: 00 the B latch, 01 the constant 4, 10 the sign-extended instruction bits [15:0], 11 those bits shifted left by 2. The ALU-result register (aluout_o) loads the ALU output on every cycle.
- R4: alu_op=00 adds and alu_op=01 subtracts. alu_op=10 decodes instruction bits [5:0]: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 signed set-less-than (result 1 or 0). Any other function code, and alu_op=11, adds. zero_o is 1 exactly when the ALU output is zero.
- R5: The PC loads when pc_load=1, or when pc_load_zero=1 and zero_o=1. Otherwise it holds.
- R6: pc_src selects the new PC value: 00 the ALU output of the same cycle, 01 the ALU-result register, 10 the jump target {PC[31:28], instruction[25:0], 2'b00}, and 11 the ALU output.
- R7: On every cycle the A latch loads register-file entry instruction[25:21] and the B latch loads entry instruction[20:16].
- R8: When rf_wr=1, the register-file entry chosen by rf_dst_sel is written at the closing clock edge: instruction[20:16] for 0, instruction[15:11] for 1. The data is the ALU-result register when rf_from_mdr=0 and the memory-data register when rf_from_mdr=1.
- R9: Register-file entry 0 always reads as zero, and writes to it have no effect.
- R10: mem_wr=1 stores the B latch at the word selected by addr_sel. ld_en=1 stores ld_data at word ld_addr. If both occur in the same cycle, the image load port's write is the one that takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_sel | input | 1 | Memory address source: 0 PC, 1 ALU-result register |
| mem_rd | input | 1 | Enables memory read data |
| mem_wr | input | 1 | Stores the B latch into memory |
| ir_load | input | 1 | Loads the instruction register |
| pc_load | input | 1 | Unconditional PC load |
| pc_load_zero | input | 1 | PC load qualified by the zero flag |
| pc_src | input | 2 | New PC source |
| src_a_sel | input | 1 | ALU operand A source |
| src_b_sel | input | 2 | ALU operand B source |
| alu_op | input | 2 | ALU operation class |
| rf_wr | input | 1 | Register-file write enable |
| rf_dst_sel | input | 1 | Register-file write address field |
| rf_from_mdr | input | 1 | Register-file write data source |
| ld_en | input | 1 | Image load write enable |
| ld_addr | input | 8 | Image load word index |
| ld_data | input | 32 | Image load data word |
| opcode_o | output | 6 | Instruction bits [31:26] |
| zero_o | output | 1 | ALU output is zero |
| pc_o | output | 32 | Program counter |
| aluout_o | output | 32 | ALU-result register |

## Verification
The assertions check the PC-update rules on every cycle. The PC holds when neither load enable is active, or when the conditional enable meets a nonzero flag. A load from the ALU-result register copies the prior value of aluout_o, and a jump always leaves a word-aligned PC. The instruction register holds unless ir_load is set, and the registered ALU result is zero exactly when the zero flag was high one cycle earlier. Other behaviour is visible only through a sequence of control cycles: register-file writes and the immunity of entry 0, the store and load round trip through the shared memory, and the function-code decoding. The bench's reference model and its directed instruction sequences show these.

// File: rtl/mcdp_pkg.sv
// Package: shared encodings for the multicycle datapath.
// Assumes a 32-bit instruction format with the opcode in [31:26].
package mcdp_pkg;
    // Internal ALU function after decoding the operation class
    typedef enum logic [2:0] {
        FN_ADD = 3'd0,
        FN_SUB = 3'd1,
        FN_AND = 3'd2,
        FN_OR  = 3'd3,
        FN_SLT = 3'd4
    } alu_fn_e;

    // Operation class from the controller
    localparam logic [1:0] OPC_ADD   = 2'b00;
    localparam logic [1:0] OPC_SUB   = 2'b01;
    localparam logic [1:0] OPC_FIELD = 2'b10;

    // Function field codes
    localparam logic [5:0] FC_ADD = 6'b100000;
    localparam logic [5:0] FC_SUB = 6'b100010;
    localparam logic [5:0] FC_AND = 6'b100100;
    localparam logic [5:0] FC_OR  = 6'b100101;
    localparam logic [5:0] FC_SLT = 6'b101010;

    // Operand B sources
    localparam logic [1:0] BSEL_REG  = 2'b00;
    localparam logic [1:0] BSEL_FOUR = 2'b01;
    localparam logic [1:0] BSEL_IMM  = 2'b10;
    localparam logic [1:0] BSEL_IMM4 = 2'b11;

    // New PC sources
    localparam logic [1:0] PSEL_ALU  = 2'b00;
    localparam logic [1:0] PSEL_HELD = 2'b01;
    localparam logic [1:0] PSEL_JUMP = 2'b10;
endpackage

// File: rtl/mcdp_alu.sv
// Module: ALU with operation-class decode and zero flag.
// Assumes the function field only matters when the class is OPC_FIELD;
// unknown codes fall back to addition.
module mcdp_alu
    import mcdp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [1:0]   op_class,
    input  logic [5:0]   func,
    output logic [W-1:0] result,
    output logic         zero
);
    alu_fn_e fn;

    // Map the class and function field onto one internal function
    always_comb begin
        fn = FN_ADD;
        if (op_class == OPC_SUB) begin
            fn = FN_SUB;
        end else if (op_class == OPC_FIELD) begin
            case (func)
                FC_SUB:  fn = FN_SUB;
                FC_AND:  fn = FN_AND;
                FC_OR:   fn = FN_OR;
                FC_SLT:  fn = FN_SLT;
                default: fn = FN_ADD;
            endcase
        end
    end

    // Compute the selected function
    always_comb begin
        case (fn)
            FN_SUB:  result = opa - opb;
            FN_AND:  result = opa & opb;
            FN_OR:   result = opa | opb;
            FN_SLT:  result = ($signed(opa) < $signed(opb)) ? W'(1) : '0;
            default: result = opa + opb;
        endcase
    end

    assign zero = (result == '0);
endmodule

// File: rtl/mcdp_regfile.sv
// Module: register file with two asynchronous read ports and one
// synchronous write port. Entry 0 is hard-wired to zero.
module mcdp_regfile #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] regs_q [DEPTH];

    // Clear on reset; write any entry except zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                regs_q[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
endmodule

// File: rtl/mcdp_mem.sv
// Module: single-port unified word memory with an image load port.
// Assumes the caller supplies the word index; contents are not reset.
module mcdp_mem #(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] idx,
    input  logic          rd_en,
    output logic [W-1:0]  rdata,
    input  logic          wr_en,
    input  logic [W-1:0]  wdata,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_idx,
    input  logic [W-1:0]  ld_data
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem_q [DEPTH];

    // Image load takes priority over a datapath store
    always_ff @(posedge clk) begin
        if (ld_en) begin
            mem_q[ld_idx] <= ld_data;
        end else if (wr_en) begin
            mem_q[idx] <= wdata;
        end
    end

    assign rdata = rd_en ? mem_q[idx] : '0;
endmodule

// File: rtl/mc_datapath.sv
// Module: multicycle datapath top. Holds the PC and the inter-cycle
// registers and wires the source muxes around the ALU, register file
// and unified memory. Assumes an external controller drives all selects.
module mc_datapath
    import mcdp_pkg::*;
#(
    parameter int W      = 32,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic              ir_load,
    input  logic              pc_load,
    input  logic              pc_load_zero,
    input  logic [1:0]        pc_src,
    input  logic              src_a_sel,
    input  logic [1:0]        src_b_sel,
    input  logic [1:0]        alu_op,
    input  logic              rf_wr,
    input  logic              rf_dst_sel,
    input  logic              rf_from_mdr,
    input  logic              ld_en,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [W-1:0]      ld_data,
    output logic [5:0]        opcode_o,
    output logic              zero_o,
    output logic [W-1:0]      pc_o,
    output logic [W-1:0]      aluout_o
);
    localparam int RF_AW  = 5;
    localparam int IMM_W  = 16;
    localparam int JMP_W  = 26;
    localparam int HI_W   = W - JMP_W - 2;

    logic [W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
    logic [W-1:0] mem_rdata, rf_rd1, rf_rd2, rf_wd;
    logic [W-1:0] opa, opb, alu_res, imm_ext, pc_next, jump_tgt;
    logic [MEM_AW-1:0] mem_idx;
    logic [RF_AW-1:0]  rf_wa;
    logic alu_zero, pc_en;

    // Word index from the PC or the held ALU result
    assign mem_idx = addr_sel ? aluout_q[MEM_AW+1:2] : pc_q[MEM_AW+1:2];

    // Operand sources
    assign imm_ext = {{(W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
    assign opa     = src_a_sel ? a_q : pc_q;
    always_comb begin
        case (src_b_sel)
            BSEL_REG:  opb = b_q;
            BSEL_FOUR: opb = W'(4);
            BSEL_IMM:  opb = imm_ext;
            default:   opb = imm_ext << 2;
        endcase
    end

    // New PC source and its enable
    assign jump_tgt = {pc_q[W-1:W-HI_W], ir_q[JMP_W-1:0], 2'b00};
    always_comb begin
        case (pc_src)
            PSEL_HELD: pc_next = aluout_q;
            PSEL_JUMP: pc_next = jump_tgt;
            default:   pc_next = alu_res;
        endcase
    end
    assign pc_en = pc_load || (pc_load_zero && alu_zero);

    // Register-file write address and data
    assign rf_wa = rf_dst_sel ? ir_q[15:11] : ir_q[20:16];
    assign rf_wd = rf_from_mdr ? mdr_q : aluout_q;

    // State registers carrying values between cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            ir_q     <= '0;
            mdr_q    <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
        end else begin
            if (pc_en)   pc_q <= pc_next;
            if (ir_load) ir_q <= mem_rdata;
            mdr_q    <= mem_rdata;
            a_q      <= rf_rd1;
            b_q      <= rf_rd2;
            aluout_q <= alu_res;
        end
    end

    mcdp_alu #(.W(W)) u_alu (
        .opa      (opa),
        .opb      (opb),
        .op_class (alu_op),
        .func     (ir_q[5:0]),
        .result   (alu_res),
        .zero     (alu_zero)
    );

    mcdp_regfile #(.W(W), .AW(RF_AW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (ir_q[25:21]),
        .ra2   (ir_q[20:16]),
        .rd1   (rf_rd1),
        .rd2   (rf_rd2),
        .we    (rf_wr),
        .wa    (rf_wa),
        .wd    (rf_wd)
    );

    mcdp_mem #(.W(W), .AW(MEM_AW)) u_mem (
        .clk     (clk),
        .idx     (mem_idx),
        .rd_en   (mem_rd),
        .rdata   (mem_rdata),
        .wr_en   (mem_wr),
        .wdata   (b_q),
        .ld_en   (ld_en),
        .ld_idx  (ld_addr),
        .ld_data (ld_data)
    );

    assign opcode_o = ir_q[31:26];
    assign zero_o   = alu_zero;
    assign pc_o     = pc_q;
    assign aluout_o = aluout_q;
endmodule

// File: rtl/mcdp_chk.sv
// Module: property checker for the multicycle datapath, bound to the top.
// Relates control inputs to the observable registers across cycles.
module mcdp_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pc_load,
    input logic         pc_load_zero,
    input logic [1:0]   pc_src,
    input logic         ir_load,
    input logic         zero_o,
    input logic [5:0]   opcode_o,
    input logic [W-1:0] pc_o,
    input logic [W-1:0] aluout_o
);
    // R5
    pc_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_load && !pc_load_zero) |=> $stable(pc_o));

    // R5
    pc_cond_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_load && pc_load_zero && !zero_o) |=> $stable(pc_o));

    // R6
    pc_from_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && pc_src == 2'b01) |=> (pc_o == $past(aluout_o)));

    // R6
    jump_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && pc_src == 2'b10) |=> (pc_o[1:0] == 2'b00));

    // R2
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_load |=> $stable(opcode_o));

    // R4
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((aluout_o == '0) == $past(zero_o)));
endmodule

bind mc_datapath mcdp_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pc_load      (pc_load),
    .pc_load_zero (pc_load_zero),
    .pc_src       (pc_src),
    .ir_load      (ir_load),
    .zero_o       (zero_o),
    .opcode_o     (opcode_o),
    .pc_o         (pc_o),
    .aluout_o     (aluout_o)
);

// File: tb/mc_datapath_tb.sv
// Bench: directed instruction sequences plus random control cycles,
// each compared every clock against a behavioural reference model.
module mc_datapath_tb;
    logic clk = 1'b0;
    logic rst_n, addr_sel, mem_rd, mem_wr, ir_load, pc_load, pc_load_zero;
    logic [1:0] pc_src, src_b_sel, alu_op;
    logic src_a_sel, rf_wr, rf_dst_sel, rf_from_mdr, ld_en;
    logic [7:0] ld_addr;
    logic [31:0] ld_data;
    logic [5:0] opcode_o;
    logic zero_o;
    logic [31:0] pc_o, aluout_o;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [31:0] m_mem [256];
    logic [31:0] m_rf [32];
    logic [31:0] m_pc, m_ir, m_mdr, m_a, m_b, m_alo;
    bit mvalid = 0;

    always #5 clk = ~clk;

    mc_datapath u_dut (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .ir_load(ir_load), .pc_load(pc_load),
        .pc_load_zero(pc_load_zero), .pc_src(pc_src), .src_a_sel(src_a_sel),
        .src_b_sel(src_b_sel), .alu_op(alu_op), .rf_wr(rf_wr),
        .rf_dst_sel(rf_dst_sel), .rf_from_mdr(rf_from_mdr), .ld_en(ld_en),
        .ld_addr(ld_addr), .ld_data(ld_data), .opcode_o(opcode_o),
        .zero_o(zero_o), .pc_o(pc_o), .aluout_o(aluout_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] ref_alu(input logic [1:0] op, input logic [5:0] fc,
                                            input logic [31:0] x, input logic [31:0] y);
        if (op == 2'b01) return x - y;
        if (op == 2'b10) begin
            if (fc == 6'h22) return x - y;
            if (fc == 6'h24) return x & y;
            if (fc == 6'h25) return x | y;
            if (fc == 6'h2a) return (signed'(x) < signed'(y)) ? 32'd1 : 32'd0;
        end
        return x + y;
    endfunction

    task automatic idle();
        addr_sel = 0; mem_rd = 0; mem_wr = 0; ir_load = 0; pc_load = 0;
        pc_load_zero = 0; pc_src = 0; src_a_sel = 0; src_b_sel = 0; alu_op = 0;
        rf_wr = 0; rf_dst_sel = 0; rf_from_mdr = 0; ld_en = 0; ld_addr = 0; ld_data = 0;
    endtask

    // One clock: check zero flag before the edge, update model, compare after
    task automatic cyc();
        logic [31:0] adr, rdv, sa, sb, imm, res, npc;
        logic z;
        logic [4:0] wa;
        #1;
        adr = addr_sel ? m_alo : m_pc;
        rdv = mem_rd ? m_mem[adr[9:2]] : 32'd0;
        sa  = src_a_sel ? m_a : m_pc;
        imm = {{16{m_ir[15]}}, m_ir[15:0]};
        case (src_b_sel)
            2'b00: sb = m_b;
            2'b01: sb = 32'd4;
            2'b10: sb = imm;
            default: sb = imm << 2;
        endcase
        res = ref_alu(alu_op, m_ir[5:0], sa, sb);
        z = (res == 32'd0);
        if (mvalid) chk("R4 zero flag", {31'd0, zero_o}, {31'd0, z});
        npc = m_pc;
        if (pc_load || (pc_load_zero && z)) begin
            if (pc_src == 2'b01) npc = m_alo;
            else if (pc_src == 2'b10) npc = {m_pc[31:28], m_ir[25:0], 2'b00};
            else npc = res;
        end
        wa = rf_dst_sel ? m_ir[15:11] : m_ir[20:16];
        @(posedge clk);
        if (ld_en) m_mem[ld_addr] = ld_data;
        else if (mem_wr) m_mem[adr[9:2]] = m_b;
        if (!rst_n) begin
            m_pc = 0; m_ir = 0; m_mdr = 0; m_a = 0; m_b = 0; m_alo = 0;
            for (int i = 0; i < 32; i++) m_rf[i] = 0;
        end else begin
            logic [31:0] wdv;
            wdv = rf_from_mdr ? m_mdr : m_alo;
            m_a = m_rf[m_ir[25:21]];
            m_b = m_rf[m_ir[20:16]];
            if (rf_wr && wa != 0) m_rf[wa] = wdv;
            m_pc = npc;
            if (ir_load) m_ir = rdv;
            m_mdr = rdv;
            m_alo = res;
        end
        mvalid = 1;
        #2;
        chk("R5 pc", pc_o, m_pc);
        chk("R2 opcode", {26'd0, opcode_o}, {26'd0, m_ir[31:26]});
        chk("R3 aluout", aluout_o, m_alo);
    endtask

    task automatic fetch();
        idle(); mem_rd = 1; ir_load = 1; src_b_sel = 2'b01; pc_load = 1; cyc();
    endtask
    task automatic decode();
        idle(); src_b_sel = 2'b11; cyc();
    endtask
    task automatic exec_r();
        idle(); src_a_sel = 1; alu_op = 2'b10; cyc();
    endtask
    task automatic load_word(input int a, input logic [31:0] d);
        idle(); ld_en = 1; ld_addr = 8'(a); ld_data = d; cyc();
    endtask

    function automatic logic [31:0] rtype(input int rs, input int rt, input int rd, input logic [5:0] fc);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fc};
    endfunction
    function automatic logic [31:0] itype(input logic [5:0] op, input int rs, input int rt, input logic [15:0] im);
        return {op, 5'(rs), 5'(rt), im};
    endfunction

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(); rst_n = 0;
        cyc(); cyc();
        // R1 reset state
        chk("R1 pc after reset", pc_o, 32'd0);
        chk("R1 opcode after reset", {26'd0, opcode_o}, 32'd0);
        chk("R1 aluout after reset", aluout_o, 32'd0);
        rst_n = 1;
        for (int i = 0; i < 256; i++) load_word(i, 32'd0);
        load_word(0,  itype(6'h08, 0, 1, 16'd5));
        load_word(1,  rtype(1, 1, 2, 6'h20));
        load_word(2,  rtype(0, 0, 0, 6'h20));
        load_word(3,  itype(6'h04, 1, 1, 16'd3));
        load_word(7,  itype(6'h04, 1, 2, 16'd1));
        load_word(8,  {6'h02, 26'h10});
        load_word(16, itype(6'h2b, 0, 2, 16'h0080));
        load_word(17, itype(6'h23, 0, 3, 16'h0080));
        load_word(18, rtype(3, 1, 4, 6'h25));
        load_word(19, rtype(1, 3, 5, 6'h2a));

        // immediate add into entry 1
        fetch();
        chk("R5 pc increment", pc_o, 32'd4);
        chk("R2 fetched opcode", {26'd0, opcode_o}, 32'h8);
        chk("R3 constant four", aluout_o, 32'd4);
        decode();
        chk("R3 shifted immediate", aluout_o, 32'd24);
        idle(); src_a_sel = 1; src_b_sel = 2'b10; cyc();
        chk("R3 immediate operand", aluout_o, 32'd5);
        idle(); rf_wr = 1; cyc();

        // register add into entry 2
        fetch(); decode(); exec_r();
        chk("R7 R4 register add", aluout_o, 32'd10);
        idle(); rf_wr = 1; rf_dst_sel = 1; cyc();

        // write attempt to entry 0
        fetch();
        idle(); src_b_sel = 2'b01; cyc();
        chk("R3 pc plus four", aluout_o, 32'd16);
        idle(); rf_wr = 1; rf_dst_sel = 1; cyc();
        idle(); cyc(); idle(); cyc();
        exec_r();
        chk("R9 entry zero reads zero", aluout_o, 32'd0);

        // taken conditional branch
        fetch(); decode();
        chk("R3 branch target", aluout_o, 32'd28);
        idle(); src_a_sel = 1; alu_op = 2'b01; pc_load_zero = 1; pc_src = 2'b01; cyc();
        chk("R5 R6 branch taken", pc_o, 32'd28);

        // not-taken conditional branch
        fetch(); decode();
        idle(); src_a_sel = 1; alu_op = 2'b01; pc_load_zero = 1; pc_src = 2'b01; cyc();
        chk("R5 branch not taken", pc_o, 32'd32);

        // jump
        fetch();
        idle(); pc_load = 1; pc_src = 2'b10; cyc();
        chk("R6 jump target", pc_o, 32'h40);

        // store entry 2, load into entry 3, then read it back
        fetch(); decode();
        idle(); src_a_sel = 1; src_b_sel = 2'b10; cyc();
        idle(); addr_sel = 1; mem_wr = 1; cyc();
        fetch(); decode();
        idle(); src_a_sel = 1; src_b_sel = 2'b10; cyc();
        idle(); addr_sel = 1; mem_rd = 1; cyc();
        idle(); rf_wr = 1; rf_from_mdr = 1; cyc();
        fetch(); decode(); exec_r();
        chk("R8 R10 R4 stored word round trip or", aluout_o, 32'd15);
        fetch(); decode(); exec_r();
        chk("R4 signed set-less-than", aluout_o, 32'd1);

        // fetch with reads disabled
        idle(); ir_load = 1; cyc();
        chk("R2 read disabled gives zero", {26'd0, opcode_o}, 32'd0);

        // random control cycles against the model
        for (int i = 0; i < 4000; i++) begin
            idle();
            addr_sel = 1'($urandom); mem_rd = 1'($urandom); ir_load = 1'($urandom);
            pc_load = ($urandom % 4) == 0; pc_load_zero = 1'($urandom);
            pc_src = 2'($urandom % 3); src_a_sel = 1'($urandom);
            src_b_sel = 2'($urandom); alu_op = 2'($urandom % 3);
            rf_wr = 1'($urandom); rf_dst_sel = 1'($urandom); rf_from_mdr = 1'($urandom);
            if (($urandom % 8) == 0) begin
                ld_en = 1; ld_addr = 8'($urandom); ld_data = $urandom;
            end else begin
                mem_wr = ($urandom % 4) == 0;
            end
            if (($urandom % 200) == 0) begin
                rst_n = 0; mem_wr = 0; ld_en = 0;
            end
            cyc();
            rst_n = 1;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule